// File: doc/BRIEF.md
# Shared-Bus Arbitration Node for a Multiprocessor Cluster

This block is the arbitration logic that sits in every processor of a cluster of up to eight processors and one host sharing one external bus. Each node owns one request line, picked by its node ID, and reads all request lines back after they have been combined on the board. Every node runs the same copy of the ownership tracker on the same sampled lines. All nodes therefore agree on who owns the bus without a central arbiter. The node that owns the bus enables its address, data and control drivers. It keeps the bus until its current transaction ends and then drops its request line.

Other parties can take the bus away from the owner. A host takes the bus through a request/grant handshake. A back-off input makes the owner let go in the middle of a transaction, which breaks read deadlocks. A lock input keeps the bus with the owner. Two shared priority lines let a node with a core access, or with high-priority DMA, push aside an owner that is running lower-class work. When the host is granted, the node that granted it also asks the memory controller to put SDRAM into self-refresh.

All lines here are active high. The board's open-drain inversion and the combining of lines are outside this block. The block carries no data stream, so it has no valid/ready interface. Every pin is a plain level.

Top module: `mpa_node`

## Requirements
- R1: The node drives only bit `id` of `req_lines_o`, where `id` is its node ID (0 selects bit 0, 7 selects bit 7). A request is a 1 on that bit. All other bits stay 0.
- R2: `node_id_i` is captured only while `rst_n` is low. A change to it outside reset has no effect on which line is driven.
- R3: When the bus is free, or when the owner's line is seen low, ownership goes to the lowest-numbered active request line at the next clock edge.
- R4: The owner asserts `master_o` and `drv_en_o` while its line is high. When it gives up the bus, its line and its drivers turn off together. The next owner takes over at the following edge, so exactly one cycle passes with no driver enabled.
- R5: An owner keeps its line high while `xfer_busy_i` is 1. It releases only at a transaction boundary, when `xfer_busy_i` is 0 and it has no more work it is allowed to do.
- R6: While `host_req_i` is 1, non-owners do not request. The owner releases at its transaction boundary. It then asserts `host_grant_o` and `sref_req_o` one cycle after its line drops, and holds them until `host_req_i` returns to 0.
- R7: A host request that arrives while the bus is free is granted by the node with ID 0 only.
- R8: `backoff_i` at the owner turns `drv_en_o` off and raises `abort_o` in the same cycle. The line drops at the next edge, even while `xfer_busy_i` is 1.
- R9: While `lock_req_i` is 1, the owner keeps the bus against the host and against priority preemption, and it raises `lock_o`.
- R10: `cpa_o` follows the core request with one cycle of delay. An owner that is not doing a core access releases at its boundary when another node raises the core-priority line. An owner that is doing a core access keeps the bus.
- R11: `dpa_o` follows "DMA request and high-priority DMA" with one cycle of delay. An owner running only normal DMA releases when another node raises the DMA-priority line. An owner running high-priority DMA keeps the bus.
- R12: A node whose work is of a lower class than an active priority line that it is not driving itself withholds its request. It requests again once that line falls.
- R13: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the node ID is captured while it is low |
| node_id_i | input | IDW | Static node ID (IDW = log2 NODES) |
| core_req_i | input | 1 | Core wants an external access |
| dma_req_i | input | 1 | A DMA channel wants an external access |
| dma_hi_i | input | 1 | The requesting DMA channel is high priority |
| xfer_busy_i | input | 1 | A transaction is in progress (not at a boundary) |
| lock_req_i | input | 1 | Core holds the bus locked |
| backoff_i | input | 1 | Host back-off: abandon the bus at once |
| host_req_i | input | 1 | Host bus request |
| req_lines_i | input | NODES | Sampled shared request lines (all nodes, own included) |
| cpa_line_i | input | 1 | Sampled shared core-priority line |
| dpa_line_i | input | 1 | Sampled shared DMA-priority line |
| req_lines_o | output | NODES | This node's request drive, one bit at most |
| cpa_o | output | 1 | Core-priority drive |
| dpa_o | output | 1 | DMA-priority drive |
| master_o | output | 1 | Node owns the bus |
| drv_en_o | output | 1 | Enable for address, data and control drivers |
| abort_o | output | 1 | Back-off abort to the transaction engine |
| lock_o | output | 1 | Bus-lock indication from the owner |
| host_grant_o | output | 1 | Host grant (driven by the granting node only) |
| sref_req_o | output | 1 | Request to put SDRAM into self-refresh while the host holds the bus |

## Verification
Arbitration is tried in two ways. With the node's request alone on the lines, the handoff into and out of ownership is seen cycle by cycle. With lower- and higher-numbered lines active at the same time as the node's own, lowest-first priority is told apart from arrival order. The release paths are driven one at a time against a node that holds the bus: host request with and without lock, busy transaction, back-off, core-priority and DMA-priority lines. Each of these is paired with the case that must not release, which tells real preemption apart from a plain release when work runs out. A reset with a different node ID, followed by an ID change outside reset, separates capturing the ID from following it live.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
  typedef enum logic [1:0] {
    BUS_FREE  = 2'd0,
    BUS_OWNED = 2'd1,
    BUS_HOST  = 2'd2
  } bus_state_e;
endpackage

// File: rtl/mpa_low_pick.sv
module mpa_low_pick #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  // lowest set bit wins; scan downward so the last hit is the lowest
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end
endmodule

// File: rtl/mpa_bus_view.sv
module mpa_bus_view
  import mpa_pkg::*;
#(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_i,
  input  logic         host_req_i,
  output bus_state_e   state_o,
  output logic [W-1:0] owner_o,
  output logic [W-1:0] granter_o
);
  bus_state_e   state_q, state_d;
  logic [W-1:0] owner_q, owner_d, granter_q, granter_d;
  logic         any_req;
  logic [W-1:0] low_idx;

  mpa_low_pick #(.N(N)) u_pick (
    .vec_i(lines_i),
    .any_o(any_req),
    .idx_o(low_idx)
  );

  // identical copy in every node: same sampled lines give the same owner
  always_comb begin
    state_d   = state_q;
    owner_d   = owner_q;
    granter_d = granter_q;
    unique case (state_q)
      BUS_FREE: begin
        if (host_req_i) begin
          state_d   = BUS_HOST;
          granter_d = '0;
        end else if (any_req) begin
          state_d = BUS_OWNED;
          owner_d = low_idx;
        end
      end
      BUS_OWNED: begin
        if (!lines_i[owner_q]) begin
          if (host_req_i) begin
            state_d   = BUS_HOST;
            granter_d = owner_q;
          end else if (any_req) begin
            owner_d = low_idx;
          end else begin
            state_d = BUS_FREE;
          end
        end
      end
      BUS_HOST: begin
        if (!host_req_i) state_d = BUS_FREE;
      end
      default: state_d = BUS_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= BUS_FREE;
      owner_q   <= '0;
      granter_q <= '0;
    end else begin
      state_q   <= state_d;
      owner_q   <= owner_d;
      granter_q <= granter_d;
    end
  end

  assign state_o   = state_q;
  assign owner_o   = owner_q;
  assign granter_o = granter_q;

  // R4: once the owner's line is seen low, that owner does not survive the edge
  p_turnover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BUS_OWNED && !lines_i[owner_q])
      |=> !(state_q == BUS_OWNED && owner_q == $past(owner_q)));

  // R3: line 0 active on a free bus without host wins
  p_low_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BUS_FREE && !host_req_i && lines_i[0])
      |=> (state_q == BUS_OWNED && owner_q == '0));

  // R6: host state persists while the host keeps requesting
  p_host_stay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BUS_HOST && host_req_i) |=> state_q == BUS_HOST);
endmodule

// File: rtl/mpa_req_ctrl.sv
module mpa_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic core_req_i,
  input  logic dma_req_i,
  input  logic dma_hi_i,
  input  logic xfer_busy_i,
  input  logic lock_req_i,
  input  logic backoff_i,
  input  logic host_req_i,
  input  logic cpa_line_i,
  input  logic dpa_line_i,
  input  logic is_owner_i,
  output logic req_o,
  output logic cpa_o,
  output logic dpa_o
);
  logic req_q, cpa_q, dpa_q;
  logic work, outranked, allowed, req_d;

  assign work = core_req_i | dma_req_i;
  // a priority line raised by someone else outranks lower-class local work
  assign outranked = (cpa_line_i & ~cpa_q) | (dpa_line_i & ~cpa_q & ~dpa_q);
  assign allowed   = work & ~outranked & ~host_req_i;

  always_comb begin
    if (is_owner_i) req_d = ~backoff_i & (lock_req_i | xfer_busy_i | allowed);
    else            req_d = allowed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cpa_q <= 1'b0;
      dpa_q <= 1'b0;
    end else begin
      req_q <= req_d;
      cpa_q <= core_req_i;
      dpa_q <= dma_req_i & dma_hi_i;
    end
  end

  assign req_o = req_q;
  assign cpa_o = cpa_q;
  assign dpa_o = dpa_q;

  // R10: core-priority drive follows the core request one cycle later
  p_cpa_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    core_req_i |=> cpa_q);

  // R12: a non-owner outranked by a priority line stays off the bus
  p_outranked_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_owner_i && outranked) |=> !req_q);
endmodule

// File: rtl/mpa_node.sv
module mpa_node
  import mpa_pkg::*;
#(
  parameter int NODES = 8,
  localparam int IDW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDW-1:0]   node_id_i,
  input  logic             core_req_i,
  input  logic             dma_req_i,
  input  logic             dma_hi_i,
  input  logic             xfer_busy_i,
  input  logic             lock_req_i,
  input  logic             backoff_i,
  input  logic             host_req_i,
  input  logic [NODES-1:0] req_lines_i,
  input  logic             cpa_line_i,
  input  logic             dpa_line_i,
  output logic [NODES-1:0] req_lines_o,
  output logic             cpa_o,
  output logic             dpa_o,
  output logic             master_o,
  output logic             drv_en_o,
  output logic             abort_o,
  output logic             lock_o,
  output logic             host_grant_o,
  output logic             sref_req_o
);
  logic [IDW-1:0] id_q;
  bus_state_e     bstate;
  logic [IDW-1:0] owner, granter;
  logic           is_owner, req_q;

  // node ID is captured only while in reset
  always_ff @(posedge clk) begin
    if (!rst_n) id_q <= node_id_i;
  end

  mpa_bus_view #(.N(NODES)) u_view (
    .clk       (clk),
    .rst_n     (rst_n),
    .lines_i   (req_lines_i),
    .host_req_i(host_req_i),
    .state_o   (bstate),
    .owner_o   (owner),
    .granter_o (granter)
  );

  assign is_owner = (bstate == BUS_OWNED) && (owner == id_q);

  mpa_req_ctrl u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_req_i (core_req_i),
    .dma_req_i  (dma_req_i),
    .dma_hi_i   (dma_hi_i),
    .xfer_busy_i(xfer_busy_i),
    .lock_req_i (lock_req_i),
    .backoff_i  (backoff_i),
    .host_req_i (host_req_i),
    .cpa_line_i (cpa_line_i),
    .dpa_line_i (dpa_line_i),
    .is_owner_i (is_owner),
    .req_o      (req_q),
    .cpa_o      (cpa_o),
    .dpa_o      (dpa_o)
  );

  assign req_lines_o  = NODES'(req_q) << id_q;
  assign master_o     = is_owner & req_q;
  assign drv_en_o     = master_o & ~backoff_i;
  assign abort_o      = master_o & backoff_i;
  assign lock_o       = master_o & lock_req_i;
  assign host_grant_o = (bstate == BUS_HOST) && (granter == id_q);
  assign sref_req_o   = host_grant_o;

  // R1: at most one request line driven
  p_one_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_lines_o));

  // R4: ownership is only claimed with the own line high on the shared lines
  p_master_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    master_o |-> req_lines_i[id_q]);

  // R5: no release in the middle of a transaction unless backed off
  p_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (master_o && xfer_busy_i && !backoff_i) |=> master_o);

  // R8: back-off removes ownership at the next edge
  p_backoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (master_o && backoff_i) |=> !master_o);

  // R9: lock keeps the bus
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (master_o && lock_req_i && !backoff_i) |=> master_o);

  // R6: grant held while the host still asks
  p_grant_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_grant_o && host_req_i) |=> host_grant_o);

  // R6: a non-owner never requests while the host asks
  p_host_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req_i && !is_owner) |=> !req_q);
endmodule

// File: tb/test_mpa_node.sv
module test_mpa_node;
  localparam int CLK_P = 10;
  localparam int N     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] node_id = 3'd2;
  logic core = 0, dma = 0, hi = 0, busy = 0, lock = 0, boff = 0, host = 0;
  logic [N-1:0] oth = '0;
  logic oth_cpa = 0, oth_dpa = 0;

  logic [N-1:0] lines_o;
  logic cpa_o, dpa_o, master_o, drv_en_o, abort_o, lock_o, hg_o, sref_o;
  logic [N-1:0] lines;

  assign lines = oth | lines_o;

  always #(CLK_P/2) clk = ~clk;

  mpa_node #(.NODES(N)) i_mpa_node (
    .clk(clk), .rst_n(rst_n), .node_id_i(node_id),
    .core_req_i(core), .dma_req_i(dma), .dma_hi_i(hi),
    .xfer_busy_i(busy), .lock_req_i(lock), .backoff_i(boff),
    .host_req_i(host), .req_lines_i(lines),
    .cpa_line_i(oth_cpa | cpa_o), .dpa_line_i(oth_dpa | dpa_o),
    .req_lines_o(lines_o), .cpa_o(cpa_o), .dpa_o(dpa_o),
    .master_o(master_o), .drv_en_o(drv_en_o), .abort_o(abort_o),
    .lock_o(lock_o), .host_grant_o(hg_o), .sref_req_o(sref_o)
  );

  typedef struct {
    logic [15:0] v;
    string       tag;
  } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // field order: lines[15:8] cpa dpa master drv abort lock grant sref
  function automatic logic [15:0] mk(logic [7:0] r, logic c, logic d, logic m,
                                     logic e, logic a, logic l, logic g);
    return {r, c, d, m, e, a, l, g, g};
  endfunction
  localparam logic [15:0] Z = 16'h0000;

  // driver: push the expectation for the coming edge, then advance one cycle
  task automatic cyc(input logic [15:0] e, input string tag);
    item_t it;
    it.v = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_now(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: sample a quarter period after each rising edge
  initial begin
    item_t it;
    logic [15:0] act;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb.size() > 0) begin
        it  = sb.pop_front();
        act = {lines_o, cpa_o, dpa_o, master_o, drv_en_o, abort_o, lock_o, hg_o, sref_o};
        n_chk++;
        if (act !== it.v) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.v);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    cyc(Z, "R13 reset state");

    // R1 own line, R4 ownership and release
    core = 1;
    cyc(mk(8'h04,1,0,0,0,0,0,0), "R1 own line bit 2");
    cyc(mk(8'h04,1,0,1,1,0,0,0), "R4 becomes master");
    core = 0;
    cyc(Z, "R4 line and drivers off together");
    cyc(Z, "R4 bus free");

    // R3 lowest first: nodes 0 and 3 request along with node 2
    oth = 8'h09; core = 1;
    cyc(mk(8'h04,1,0,0,0,0,0,0), "R3 node 0 wins over 2 and 3");
    cyc(mk(8'h04,1,0,0,0,0,0,0), "R3 waiting behind node 0");
    oth = 8'h08;
    cyc(mk(8'h04,1,0,1,1,0,0,0), "R3 node 2 beats node 3 after turnaround R4");
    core = 0;
    cyc(Z, "R4 release");
    cyc(Z, "R3 node 3 takes over");
    oth = '0;
    cyc(Z, "R3 bus free");

    // R5 transaction boundary
    core = 1;
    cyc(mk(8'h04,1,0,0,0,0,0,0), "R5 request");
    cyc(mk(8'h04,1,0,1,1,0,0,0), "R5 master");
    core = 0; busy = 1;
    cyc(mk(8'h04,0,0,1,1,0,0,0), "R5 held while busy");
    cyc(mk(8'h04,0,0,1,1,0,0,0), "R5 still held");
    busy = 0;
    cyc(Z, "R5 release at boundary");
    cyc(Z, "R5 bus free");

    // R9 lock against host, then R6 handoff
    core = 1;
    cyc(mk(8'h04,1,0,0,0,0,0,0), "R9 request");
    cyc(mk(8'h04,1,0,1,1,0,0,0), "R9 master");
    lock = 1; host = 1;
    cyc(mk(8'h04,1,0,1,1,0,1,0), "R9 lock holds against host");
    cyc(mk(8'h04,1,0,1,1,0,1,0), "R9 lock still holds");
    lock = 0;
    cyc(mk(8'h00,1,0,0,0,0,0,0), "R6 owner releases for host");
    cyc(mk(8'h00,1,0,0,0,0,0,1), "R6 grant and self-refresh");
    cyc(mk(8'h00,1,0,0,0,0,0,1), "R6 grant held");
    host = 0;
    cyc(mk(8'h04,1,0,0,0,0,0,0), "R6 grant dropped, request again");
    cyc(mk(8'h04,1,0,1,1,0,0,0), "R6 master again");
    core = 0;
    cyc(Z, "R6 release");
    cyc(Z, "R6 bus free");

    // R6/R7 host request on a free bus, node 2 must neither grant nor request
    host = 1; core = 1;
    cyc(mk(8'h00,1,0,0,0,0,0,0), "R7 no grant from node 2 and R6 no request");
    cyc(mk(8'h00,1,0,0,0,0,0,0), "R6 still quiet");
    host = 0;
    cyc(mk(8'h04,1,0,0,0,0,0,0), "R6 request after host");
    cyc(mk(8'h04,1,0,1,1,0,0,0), "R6 master after host");
    core = 0;
    cyc(Z, "R6 release");
    cyc(Z, "R6 bus free");

    // R8 back-off mid-transaction
    core = 1;
    cyc(mk(8'h04,1,0,0,0,0,0,0), "R8 request");
    cyc(mk(8'h04,1,0,1,1,0,0,0), "R8 master");
    busy = 1; boff = 1;
    #1;
    chk_now(drv_en_o, 1'b0, "R8 drivers off at once");
    chk_now(abort_o, 1'b1, "R8 abort raised");
    cyc(mk(8'h00,1,0,0,0,0,0,0), "R8 line dropped while busy");
    boff = 0; busy = 0;
    cyc(mk(8'h04,1,0,0,0,0,0,0), "R8 request again");
    cyc(mk(8'h04,1,0,1,1,0,0,0), "R8 master again");
    core = 0;
    cyc(Z, "R8 release");
    cyc(Z, "R8 bus free");

    // R10 normal DMA owner preempted by core priority, R12 withheld request
    dma = 1;
    cyc(mk(8'h04,0,0,0,0,0,0,0), "R10 dma request");
    cyc(mk(8'h04,0,0,1,1,0,0,0), "R10 dma master");
    oth = 8'h08; oth_cpa = 1;
    cyc(Z, "R10 normal dma preempted by core priority");
    cyc(Z, "R12 request withheld while outranked");
    oth = '0; oth_cpa = 0;
    cyc(mk(8'h04,0,0,0,0,0,0,0), "R12 request resumes");
    cyc(mk(8'h04,0,0,1,1,0,0,0), "R12 master again");
    dma = 0;
    cyc(Z, "R10 release");
    cyc(Z, "R10 bus free");

    // R10 core owner is not preempted
    core = 1;
    cyc(mk(8'h04,1,0,0,0,0,0,0), "R10 core request");
    cyc(mk(8'h04,1,0,1,1,0,0,0), "R10 core master");
    oth = 8'h08; oth_cpa = 1;
    cyc(mk(8'h04,1,0,1,1,0,0,0), "R10 core master kept");
    core = 0; oth = '0; oth_cpa = 0;
    cyc(Z, "R10 release");
    cyc(Z, "R10 bus free");

    // R11 DMA priority
    dma = 1;
    cyc(mk(8'h04,0,0,0,0,0,0,0), "R11 normal dma request");
    cyc(mk(8'h04,0,0,1,1,0,0,0), "R11 normal dma master");
    oth = 8'h08; oth_dpa = 1;
    cyc(Z, "R11 normal dma preempted");
    cyc(Z, "R11 withheld");
    oth = '0; oth_dpa = 0;
    cyc(mk(8'h04,0,0,0,0,0,0,0), "R11 request resumes");
    cyc(mk(8'h04,0,0,1,1,0,0,0), "R11 master again");
    dma = 0;
    cyc(Z, "R11 release");
    cyc(Z, "R11 bus free");
    dma = 1; hi = 1;
    cyc(mk(8'h04,0,1,0,0,0,0,0), "R11 high dma request");
    cyc(mk(8'h04,0,1,1,1,0,0,0), "R11 high dma master");
    oth = 8'h08; oth_dpa = 1;
    cyc(mk(8'h04,0,1,1,1,0,0,0), "R11 high dma kept");
    dma = 0; hi = 0; oth = '0; oth_dpa = 0;
    cyc(Z, "R11 release");
    cyc(Z, "R11 bus free");

    // R2 / R7: reset with ID 0
    rst_n = 0; node_id = 3'd0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    host = 1;
    cyc(mk(8'h00,0,0,0,0,0,0,1), "R7 node 0 grants host on free bus");
    host = 0;
    cyc(Z, "R7 grant removed");
    node_id = 3'd5; core = 1;
    cyc(mk(8'h01,1,0,0,0,0,0,0), "R2 ID change outside reset ignored, R1 bit 0");
    cyc(mk(8'h01,1,0,1,1,0,0,0), "R2 master as node 0");
    core = 0;
    cyc(Z, "R2 release");
    cyc(Z, "R2 bus free");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule